// File: doc/BRIEF.md
# Reaction Timer with Thermometer Display

The block measures how quickly a person answers a light. Reset doubles as the start input. Once reset is released, a prescaler divides the system clock into a timing tick. A settle phase then runs for a fixed number of ticks. During this phase a shift register is loaded with ones from its serial end.

When the settle phase ends, the ready lamp turns on. From then on, every tick pushes a zero into the register, so the lit part of the eight-lamp bar gets shorter by one position per tick. When the person presses stop, the register freezes. The number of lamps still lit shows how fast the person reacted: more lit lamps means a faster reaction.

The stop button passes through a two-flop synchronizer. Only a rising edge seen while the ready lamp is on counts as a press. A button pressed early, or held down since before the lamp lit, therefore cannot stop the timer.

Top module: `reaction_timer`

## Requirements
- R1: While `rst` is high, `readyLed` is 0 and `ledBar` is all zeros. The stop latch is also cleared, so a later test is not frozen.
- R2: `ledBar` changes only on a tick. A tick occurs on every `TICK_DIV`-th clock edge after reset release, and the first tick is on edge number `TICK_DIV`.
- R3: Before ready, each tick shifts a 1 into bit `WIDTH-1`. `readyLed` rises on clock edge `TICK_DIV*DELAY_TICKS` after reset release, and on that edge `ledBar` is all ones (this needs `DELAY_TICKS >= WIDTH`).
- R4: After ready, each tick shifts a 0 into bit `WIDTH-1` and moves every bit one place toward bit 0. After m such ticks, `ledBar` equals all ones shifted right by m.
- R5: Once lit, `readyLed` stays on until the next reset.
- R6: A rising edge of the synchronized stop button while `readyLed` is on freezes `ledBar`. A tick on the second clock edge after the first edge that samples the button high is still taken. Every later tick is not taken.
- R7: A stop press before `readyLed` lights has no effect. This holds whether the button is tapped and released before the lamp lights, or held down from before the lamp lights until after.
- R8: Without a valid stop, `ledBar` drains to all zeros and stays there.
- R9: Once frozen, further stop presses leave `ledBar` unchanged.
- R10: Asserting `rst` in the middle of a test and releasing it restarts the settle phase. The full timing of R3 then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also starts a new test |
| stopBtn | input | 1 | Raw stop push-button, asynchronous |
| readyLed | output | 1 | Lamp that tells the subject to react |
| ledBar | output | WIDTH | Thermometer result; bit WIDTH-1 is the first to go dark |

## Verification
Stops are placed at several distances from the ready edge. The shortest lands before the first drain tick and must leave all lamps lit. A design with one synchronizer stage too few or too many, or a latch that gates the tick one cycle late, ends with one lamp more or fewer than expected. A press held down from the settle phase must be ignored; a level-sensitive design would freeze at once. A second press after a freeze must not restart or shift the bar. A mid-test reset must clear the latch and repeat the exact settle timing.

// File: rtl/rt_pkg.sv
package rt_pkg;
  // Strobes passed from control to the datapath once per clock
  typedef struct packed {
    logic shiftEn;   // take one shift this cycle
    logic serialIn;  // bit entering at the MSB end
  } rtStrobe_t;
endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
  parameter int TICK_DIV = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  output logic tickPulse
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cntQ;

  assign tickPulse = (cntQ == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cntQ <= '0;
    else if (tickPulse) cntQ <= '0;
    else                cntQ <= cntQ + 1'b1;
  end

  // R2: a tick lasts exactly one cycle
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tickPulse |=> !tickPulse);
endmodule

// File: rtl/rt_control.sv
module rt_control
  import rt_pkg::*;
#(
  parameter int DELAY_TICKS = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickPulse,
  input  logic       stopBtn,
  output rtStrobe_t  strobes,
  output logic       readyLed
);
  localparam int DW = $clog2(DELAY_TICKS + 1);
  localparam logic [DW-1:0] LAST_D = DW'(DELAY_TICKS - 1);

  logic [1:0]    syncQ;
  logic          prevQ;
  logic          btnRise;
  logic          readyQ;
  logic          stoppedQ;
  logic [DW-1:0] delayCnt;

  // two-flop synchronizer plus edge detector
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], stopBtn};
      prevQ <= syncQ[1];
    end
  end

  assign btnRise = syncQ[1] & ~prevQ;

  // settle phase counter and ready lamp
  always_ff @(posedge clk) begin
    if (rst) begin
      delayCnt <= '0;
      readyQ   <= 1'b0;
    end else if (tickPulse && !readyQ) begin
      delayCnt <= delayCnt + 1'b1;
      if (delayCnt == LAST_D) readyQ <= 1'b1;
    end
  end

  // stop latch: armed only while the lamp is lit
  always_ff @(posedge clk) begin
    if (rst)                    stoppedQ <= 1'b0;
    else if (readyQ && btnRise) stoppedQ <= 1'b1;
  end

  assign strobes.shiftEn  = tickPulse & ~stoppedQ;
  assign strobes.serialIn = ~readyQ;
  assign readyLed         = readyQ;

  // R5: lamp stays lit until reset
  assert_ready_holds_R5: assert property (@(posedge clk) disable iff (rst)
    readyQ |=> readyQ);
  // R7: latch can only be set once the lamp is lit
  assert_stop_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
    stoppedQ |-> readyQ);
  // R9: latch is sticky
  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (rst)
    stoppedQ |=> stoppedQ);
endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  rtStrobe_t        strobes,
  output logic [WIDTH-1:0] ledBar
);
  logic [WIDTH-1:0] shiftQ;

  generate
    if (WIDTH > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)                  shiftQ <= '0;
        else if (strobes.shiftEn) shiftQ <= {strobes.serialIn, shiftQ[WIDTH-1:1]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)                  shiftQ <= '0;
        else if (strobes.shiftEn) shiftQ <= strobes.serialIn;
      end
    end
  endgenerate

  assign ledBar = shiftQ;

  // R2: no strobe, no movement
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> $stable(shiftQ));
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int TICK_DIV    = 2_500_000,
  parameter int DELAY_TICKS = 70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stopBtn,
  output logic             readyLed,
  output logic [WIDTH-1:0] ledBar
);
  logic      tickPulse;
  rtStrobe_t strobes;

  rt_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk(clk), .rst(rst), .tickPulse(tickPulse)
  );

  rt_control #(.DELAY_TICKS(DELAY_TICKS)) i_ctrl (
    .clk(clk), .rst(rst), .tickPulse(tickPulse), .stopBtn(stopBtn),
    .strobes(strobes), .readyLed(readyLed)
  );

  rt_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .ledBar(ledBar)
  );

  // R3: bar is full on the edge the lamp lights
  assert_full_at_ready_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(readyLed) |-> (&ledBar));
  // R8: an empty bar after ready stays empty
  assert_empty_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (readyLed && ledBar == '0) |=> (ledBar == '0));
endmodule

// File: tb/test_reaction_timer.sv
`timescale 1ns/1ps
module test_reaction_timer;
  localparam int W   = 8;
  localparam int DIV = 4;
  localparam int DLY = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stopBtn = 1'b0;
  logic readyLed;
  logic [W-1:0] ledBar;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  reaction_timer #(.WIDTH(W), .TICK_DIV(DIV), .DELAY_TICKS(DLY)) i_reaction_timer (
    .clk(clk), .rst(rst), .stopBtn(stopBtn), .readyLed(readyLed), .ledBar(ledBar)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // counts negedges until the lamp is seen; lands on the negedge after the rising edge
  task automatic waitReady(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (readyLed) break;
    end
  endtask

  function automatic logic [W-1:0] expectBar(input int d);
    int m = (d + 3) / DIV;
    if (m > W) m = W;
    return {W{1'b1}} >> m;
  endfunction

  task automatic t_reset();
    int n;
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", {{(W-1){1'b0}}, readyLed}, '0);
    chk("R1 bar in reset", ledBar, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 bar before first tick", ledBar, '0);
    waitReady(n);
  endtask

  task automatic t_fill();
    int n;
    resetDut();
    waitReady(n);
    chk("R3 settle length", W'(n), W'(DIV * DLY));
    chk("R3 bar full at ready", ledBar, '1);
    repeat (DIV - 1) @(negedge clk);
    chk("R2 bar steady between ticks", ledBar, '1);
    @(negedge clk);
    chk("R4 first drain tick", ledBar, {1'b0, {(W-1){1'b1}}});
  endtask

  task automatic t_stop(input int d);
    int n;
    logic [W-1:0] held;
    resetDut();
    waitReady(n);
    repeat (d) @(negedge clk);
    stopBtn = 1'b1;
    repeat (12) @(negedge clk);
    held = ledBar;
    chk($sformatf("R6 freeze at d=%0d", d), held, expectBar(d));
    repeat (3 * DIV) @(negedge clk);
    chk($sformatf("R6 stays frozen d=%0d", d), ledBar, held);
    stopBtn = 1'b0;
    chk("R5 lamp still on", {{(W-1){1'b0}}, readyLed}, 1);
  endtask

  task automatic t_second_press();
    t_stop(5);
    repeat (4) @(negedge clk);
    stopBtn = 1'b1;
    repeat (5 * DIV) @(negedge clk);
    chk("R9 second press ignored", ledBar, expectBar(5));
    stopBtn = 1'b0;
  endtask

  task automatic t_early_hold();
    int n;
    resetDut();
    repeat (5) @(negedge clk);
    stopBtn = 1'b1;
    waitReady(n);
    repeat (W * DIV + 8) @(negedge clk);
    chk("R7 held early press ignored", ledBar, '0);
    stopBtn = 1'b0;
  endtask

  task automatic t_early_tap();
    int n;
    resetDut();
    repeat (10) @(negedge clk);
    stopBtn = 1'b1;
    repeat (3) @(negedge clk);
    stopBtn = 1'b0;
    waitReady(n);
    repeat (W * DIV + 8) @(negedge clk);
    chk("R7 tapped early press ignored", ledBar, '0);
    repeat (4 * DIV) @(negedge clk);
    chk("R8 empty bar stays empty", ledBar, '0);
  endtask

  task automatic t_restart();
    int n;
    t_stop(5);
    resetDut();
    chk("R10 bar cleared by restart", ledBar, '0);
    chk("R10 lamp cleared by restart", {{(W-1){1'b0}}, readyLed}, '0);
    waitReady(n);
    chk("R10 settle length repeats", W'(n), W'(DIV * DLY));
    chk("R10 bar full again", ledBar, '1);
    repeat (DIV * 3) @(negedge clk);
    chk("R10 latch cleared, draining", ledBar, {W{1'b1}} >> 3);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_stop(0);
    t_stop(5);
    t_stop(13);
    t_stop(30);
    t_second_press();
    t_early_hold();
    t_early_tap();
    t_restart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule